// File: doc/BRIEF.md
# Widening Signed Vector Left Shifter

The block shifts every element of a signed integer vector left by one common amount, producing results twice as wide as the inputs. The vector has N elements of W bits each, with W set to 8, 16 or 32 by a parameter. Each element is first sign-extended to 2W bits and then shifted left by an unsigned count. Zeros fill in from the bottom.

The widened results take twice the storage of the input, so they are split across two output vectors of the same total width as the input. One output vector carries the lower half of the elements. The other carries the upper half. Each output vector also has three condition flags: zero, negative and carry-out.

A new operation can be issued on every clock cycle. Its results appear after a fixed two-stage pipeline.

Top module: `widen_shl_vec`

## Requirements
- R1: Each input element (element j at in_vec[j*W +: W]) is sign-extended to 2W bits and shifted left by the unsigned count shamt. The same count applies to all elements, and zeros fill the vacated low bits.
- R2: r0 holds the results of input elements 0 to N/2-1, and r1 holds those of elements N/2 to N-1. Result k of each output sits at bits [k*2W +: 2W], with the input order kept.
- R3: A count of 0 yields the plain sign-extended input element.
- R4: A count of 2W or more yields all-zero result elements.
- R5: zf[0] (for r0) and zf[1] (for r1) are 1 exactly when every result element of that output vector is zero.
- R6: nf[0] and nf[1] are 1 exactly when at least one result element of that output vector has its top bit (bit 2W-1) set.
- R7: cf[0] and cf[1] are 1 exactly when, in some element of that output vector, a bit shifted out above bit 2W-1 differs from the result's top bit. For a count of 2W or more, the whole extended value is shifted out, so the flag is set when that element is nonzero.
- R8: out_valid rises exactly two rising clock edges after in_valid is sampled high, once for each accepted operation, and stays low otherwise.
- R9: Operations issued on consecutive cycles each return their own correct result, in issue order, on consecutive cycles.
- R10: While rst_n is low, out_valid, r0, r1 and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation issued this cycle |
| in_vec | input | N*W | Input vector of N signed W-bit elements |
| shamt | input | SW | Unsigned left-shift count, common to all elements |
| out_valid | output | 1 | Results and flags valid |
| r0 | output | N*W | Widened results of the lower input half |
| r1 | output | N*W | Widened results of the upper input half |
| zf | output | 2 | Zero flag per output vector (bit 0: r0, bit 1: r1) |
| nf | output | 2 | Negative flag per output vector |
| cf | output | 2 | Carry-out flag per output vector |

## Verification
Assertions check the following properties on every cycle:
- out_valid follows a valid first stage by exactly one cycle, and never appears without one.
- A zero flag always agrees with its output vector being all zero, and a set negative flag rules out a set zero flag.
- An out-of-range count always gives zero results.
- A count of zero never raises carry.

Only the bench scenarios can show that the numeric results and carry values are correct for mixed signs, boundary counts such as 2W-1, 2W and 255, and back-to-back streams in issue order. The reset state is also checked by a bench scenario.

// File: rtl/widen_shl_vec.sv
module widen_shl_vec #(
  parameter int N  = 4,
  parameter int W  = 8,
  parameter int SW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [N*W-1:0]  in_vec,
  input  logic [SW-1:0]   shamt,
  output logic            out_valid,
  output logic [N*W-1:0]  r0,
  output logic [N*W-1:0]  r1,
  output logic [1:0]      zf,
  output logic [1:0]      nf,
  output logic [1:0]      cf
);
  localparam int DW = 2 * W;
  localparam int QW = 4 * W;
  localparam int H  = N / 2;
  localparam logic [SW-1:0] DWS = SW'(DW);

  logic            v1;
  logic [SW-1:0]   s1;
  logic [N*DW-1:0] ext_d, ext1, res_d;
  logic [N-1:0]    ng_e, cy_e;
  logic [1:0]      zf_d, nf_d, cf_d;

  // Stage 1: sign extension
  for (genvar i = 0; i < N; i++) begin : g_ext
    assign ext_d[i*DW +: DW] = {{W{in_vec[i*W+W-1]}}, in_vec[i*W +: W]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1   <= 1'b0;
      s1   <= '0;
      ext1 <= '0;
    end else begin
      v1   <= in_valid;
      s1   <= shamt;
      ext1 <= ext_d;
    end
  end

  // Stage 2: shift, carry detection
  logic big;
  assign big = (s1 >= DWS);

  for (genvar i = 0; i < N; i++) begin : g_shl
    logic [DW-1:0] e;
    logic [QW-1:0] wide;
    assign e    = ext1[i*DW +: DW];
    assign wide = {{(QW-DW){e[DW-1]}}, e} << s1;
    assign res_d[i*DW +: DW] = big ? '0 : wide[DW-1:0];
    assign cy_e[i] = big ? (|e) : (wide[QW-1:DW] != {DW{wide[DW-1]}});
    assign ng_e[i] = res_d[i*DW+DW-1];
  end

  for (genvar h = 0; h < 2; h++) begin : g_flag
    assign zf_d[h] = ~|res_d[h*H*DW +: H*DW];
    assign nf_d[h] = |ng_e[h*H +: H];
    assign cf_d[h] = |cy_e[h*H +: H];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      r0 <= '0;
      r1 <= '0;
      zf <= '0;
      nf <= '0;
      cf <= '0;
    end else begin
      out_valid <= v1;
      r0 <= res_d[H*DW-1:0];
      r1 <= res_d[N*DW-1:H*DW];
      zf <= zf_d;
      nf <= nf_d;
      cf <= cf_d;
    end
  end

  p_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    v1 |=> out_valid);
  p_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(v1));
  p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (zf[0] == (r0 == '0)) && (zf[1] == (r1 == '0)));
  p_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(nf[0] && zf[0]) && !(nf[1] && zf[1]));
  p_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && big) |=> (r0 == '0) && (r1 == '0) && (zf == 2'b11));
  p_nocarry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && s1 == '0) |=> (cf == 2'b00));
endmodule

// File: tb/widen_shl_vec_tb.sv
module widen_shl_vec_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int W  = 8;
  localparam int SW = 8;
  localparam int DW = 2 * W;
  localparam int H  = N / 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [N*W-1:0]  in_vec = '0;
  logic [SW-1:0]   shamt = '0;
  logic            out_valid;
  logic [N*W-1:0]  r0, r1;
  logic [1:0]      zf, nf, cf;

  widen_shl_vec #(.N(N), .W(W), .SW(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec),
    .shamt(shamt), .out_valid(out_valid), .r0(r0), .r1(r1),
    .zf(zf), .nf(nf), .cf(cf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [N*W-1:0] r0, r1;
    logic [1:0]     z, n, c;
    string          tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int failures = 0;
  logic [1:0] hist;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [N*W-1:0] v, input int s, input string tag);
    item_t it;
    logic [N*DW-1:0] all;
    logic [N-1:0] cy;
    all = '0;
    for (int j = 0; j < N; j++) begin
      longint x, p;
      logic [DW-1:0] res;
      x = longint'($signed(v[j*W +: W]));
      if (s >= DW) begin
        res = '0;
        cy[j] = (x != 0);
      end else begin
        p = x * (longint'(1) << s);
        res = p[DW-1:0];
        cy[j] = (p < -(longint'(1) << (DW-1))) || (p >= (longint'(1) << (DW-1)));
      end
      all[j*DW +: DW] = res;
    end
    it.r0 = all[H*DW-1:0];
    it.r1 = all[N*DW-1:H*DW];
    it.z[0] = (it.r0 == '0);
    it.z[1] = (it.r1 == '0);
    it.n = '0;
    for (int k = 0; k < H; k++) begin
      it.n[0] |= it.r0[k*DW+DW-1];
      it.n[1] |= it.r1[k*DW+DW-1];
    end
    it.c[0] = |cy[H-1:0];
    it.c[1] = |cy[N-1:H];
    it.tag = tag;
    q.push_back(it);
    in_valid = 1'b1;
    in_vec = v;
    shamt = SW'(s);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk or negedge rst_n)
    if (!rst_n) hist <= 2'b00;
    else hist <= {hist[0], in_valid};

  always @(negedge clk) begin
    if (rst_n) begin
      chk(out_valid === hist[1], "R8", "out_valid", 128'(out_valid), 128'(hist[1]));
      if (out_valid) begin
        if (q.size() == 0) begin
          chk(1'b0, "R8", "unexpected result", 128'(1), 128'(0));
        end else begin
          item_t e;
          e = q.pop_front();
          chk(r0 === e.r0, {e.tag, "/R1/R2"}, "r0", 128'(r0), 128'(e.r0));
          chk(r1 === e.r1, {e.tag, "/R1/R2"}, "r1", 128'(r1), 128'(e.r1));
          chk(zf === e.z, {e.tag, "/R5"}, "zf", 128'(zf), 128'(e.z));
          chk(nf === e.n, {e.tag, "/R6"}, "nf", 128'(nf), 128'(e.n));
          chk(cf === e.c, {e.tag, "/R7"}, "cf", 128'(cf), 128'(e.c));
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R10", "out_valid in reset", 128'(out_valid), 128'(0));
    chk({r0, r1} === '0, "R10", "results in reset", 128'({r0, r1}), 128'(0));
    chk({zf, nf, cf} === '0, "R10", "flags in reset", 128'({zf, nf, cf}), 128'(0));
    rst_n = 1'b1;
    idle(2);
    send({8'h80, 8'h7F, 8'hFF, 8'h01}, 0, "R3");
    idle(3);
    send({8'h12, 8'hF3, 8'h40, 8'h81}, 4, "R1");
    send({8'h01, 8'hFF, 8'h02, 8'h00}, 15, "R7");
    send({8'h00, 8'h00, 8'hC0, 8'h00}, 1, "R6");
    send({8'h55, 8'h80, 8'h7F, 8'h01}, 16, "R4");
    send({8'hAA, 8'h01, 8'hFF, 8'h80}, 255, "R4");
    send({8'h00, 8'h00, 8'h00, 8'h00}, 3, "R5");
    send({8'h03, 8'h00, 8'h00, 8'h00}, 2, "R5");
    idle(4);
    for (int i = 0; i < 12; i++)
      send({8'(i*37+5), 8'(i*91+200), 8'(i*13+128), 8'(255-i*29)}, i*3, "R9");
    idle(5);
    chk(q.size() == 0, "R8", "pending results", 128'(q.size()), 128'(0));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule